// File: doc/BRIEF.md
# Head Stepper Phase Sequencer

This block turns the host's step and direction lines into the four coil enables of a unipolar four-phase stepper that moves a disk head carriage. Each step that the block executes changes the coil phase by one position, and each phase change moves the head by one track. The phase lives in a two-bit Gray register. On every executed step exactly one of its two flops toggles. The flop that toggles is picked by an XOR of the direction line with the current flop outputs.

The carriage has a limit switch near the outer edge. That switch closes over several tracks and is noisy, so its active-low input is first passed through a counter debouncer. Track zero is reported only when the debounced switch is closed and the phase register sits at phase 0. While track zero is reported, outward steps are refused, so the carriage never passes below track zero. A step is also refused while the drive is not selected or a write is in progress.

All control inputs cross a synchronizer of `SYNC_STAGES` flops before any logic uses them. A step request acts on its rising edge only. For each executed step the block raises a one-cycle pulse.

Top module: `head_step_seq`

## Requirements
- R1: After reset the phase is 0, so `coil_en` is 4'b0001. `step_pulse` is low and `trk0_flag` is low.
- R2: `coil_en` is always one-hot, and bit i is set exactly when the phase is i.
- R3: An executed step with `step_dir` = 1 (inward) moves the phase 0→1→2→3→0.
- R4: An executed step with `step_dir` = 0 (outward) moves the phase 3→2→1→0→3.
- R5: A step acts only on a rising edge of `step_req`. A line held high yields one step.
- R6: A step is ignored while `drive_sel` is low or `write_busy` is high.
- R7: `trk0_sw_n` is active low. The debounced switch state changes only after the synchronized input has differed from it for `DEBOUNCE_CYCLES` consecutive clocks. A shorter pulse is ignored.
- R8: `trk0_flag` is high exactly when the debounced switch is closed and the phase is 0.
- R9: While `trk0_flag` is high, outward steps are ignored. Inward steps are still executed.
- R10: `step_pulse` is high for one clock per executed step, in the same cycle as the new `coil_en`. `coil_en` does not change otherwise.
- R11: Each phase change flips exactly one bit of the internal Gray phase register.
- R12: Inputs are sampled through `SYNC_STAGES` flops. A rising edge of `step_req` that is accepted shows on `step_pulse` and `coil_en` `SYNC_STAGES`+1 clock edges after it is first sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| drive_sel | input | 1 | Drive selected, active high |
| write_busy | input | 1 | Write in progress, active high |
| step_req | input | 1 | Step request, acts on its rising edge |
| step_dir | input | 1 | 1 = inward (phase up), 0 = outward (phase down) |
| trk0_sw_n | input | 1 | Raw track-zero limit switch, active low |
| coil_en | output | 4 | One-hot coil enables, bit index = phase |
| trk0_flag | output | 1 | Track zero reported |
| step_pulse | output | 1 | One-cycle pulse per executed step |

## Verification
The bench goes after the outward step taken at phase 0 with the switch closed. A design that did not block it would show `coil_en` = 4'b1000 and a pulse, which is the track below zero. It also drives a switch glitch shorter than the debounce window and holds the step line high for many cycles. A weak debouncer would raise `trk0_flag` on the glitch, and a level-sensitive step would walk several phases. Finally, it closes the switch away from phase 0 and moves in and out of phase 0 with the switch held. A flag decoded from the switch alone would stay high at phases 1 to 3.

// File: rtl/hs_pkg.sv
package hs_pkg;

   typedef logic [1:0] gray_t;

   localparam gray_t GRAY_P0 = 2'b00;

   typedef struct packed {
      logic sel;
      logic wr;
      logic step;
      logic dir;
      logic sw_n;
   } ctl_t;

   localparam ctl_t CTL_RST = '{sel: 1'b0, wr: 1'b0, step: 1'b0, dir: 1'b0, sw_n: 1'b1};

   function automatic logic [1:0] gray_to_idx(input gray_t g);
      return {g[1], g[1] ^ g[0]};
   endfunction

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
   parameter int W = 1,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("hs_sync: STAGES must be 0..4");
   end

   if (STAGES == 0) begin : g_pass
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] stage [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
         end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
         end
      end
      assign q = stage[STAGES-1];
   end

endmodule

// File: rtl/hs_debounce.sv
module hs_debounce #(
   parameter int CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic stable
);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("hs_debounce: CYCLES must be at least 1");
   end

   if (CYCLES == 1) begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stable <= 1'b0;
         else        stable <= raw;
      end
   end else begin : g_count
      localparam int CNT_W = $clog2(CYCLES);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stable <= 1'b0;
            cnt    <= '0;
         end else if (raw == stable) begin
            cnt <= '0;
         end else if (cnt == LAST) begin
            stable <= raw;
            cnt    <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/hs_phase_core.sv
module hs_phase_core
   import hs_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  advance,
   input  logic  inward,
   output gray_t gray
);

   logic flip_hi;
   logic flip_lo;

   // the XOR of direction and flop outputs picks the one flop to toggle
   assign flip_hi = ~(inward ^ (gray[1] ^ gray[0]));
   assign flip_lo = ~flip_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gray <= GRAY_P0;
      end else if (advance) begin
         gray[1] <= gray[1] ^ flip_hi;
         gray[0] <= gray[0] ^ flip_lo;
      end
   end

endmodule

// File: rtl/hs_coil_decode.sv
module hs_coil_decode
   import hs_pkg::*;
#(
   parameter int NUM_COILS = 4
) (
   input  gray_t                gray,
   output logic [NUM_COILS-1:0] coil_en
);

   if (NUM_COILS != 4) begin : g_bad_coils
      $error("hs_coil_decode: only four coils are supported");
   end

   logic [1:0] idx;
   assign idx = gray_to_idx(gray);

   for (genvar i = 0; i < NUM_COILS; i++) begin : g_coil
      assign coil_en[i] = (idx == 2'(i));
   end

endmodule

// File: rtl/head_step_seq.sv
module head_step_seq
   import hs_pkg::*;
#(
   parameter int SYNC_STAGES     = 2,
   parameter int DEBOUNCE_CYCLES = 8,
   parameter int NUM_COILS       = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 drive_sel,
   input  logic                 write_busy,
   input  logic                 step_req,
   input  logic                 step_dir,
   input  logic                 trk0_sw_n,
   output logic [NUM_COILS-1:0] coil_en,
   output logic                 trk0_flag,
   output logic                 step_pulse
);

   localparam int CTL_W = $bits(ctl_t);

   ctl_t             ctl_raw;
   logic [CTL_W-1:0] ctl_s_vec;
   ctl_t             ctl_s;
   logic             sel_s;
   logic             wr_s;
   logic             step_prev;
   logic             step_rise;
   logic             sw_closed;
   gray_t            gray;
   logic             outward_block;
   logic             accept;

   assign ctl_raw = '{sel: drive_sel, wr: write_busy, step: step_req,
                      dir: step_dir, sw_n: trk0_sw_n};

   hs_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_RST)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ctl_raw),
      .q     (ctl_s_vec)
   );

   assign ctl_s = ctl_t'(ctl_s_vec);
   assign sel_s = ctl_s.sel;
   assign wr_s  = ctl_s.wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) step_prev <= 1'b0;
      else        step_prev <= ctl_s.step;
   end
   assign step_rise = ctl_s.step & ~step_prev;

   hs_debounce #(.CYCLES(DEBOUNCE_CYCLES)) u_deb (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw    (~ctl_s.sw_n),
      .stable (sw_closed)
   );

   assign trk0_flag     = sw_closed & (gray == GRAY_P0);
   assign outward_block = trk0_flag & ~ctl_s.dir;
   assign accept        = step_rise & sel_s & ~wr_s & ~outward_block;

   hs_phase_core u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (accept),
      .inward  (ctl_s.dir),
      .gray    (gray)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) step_pulse <= 1'b0;
      else        step_pulse <= accept;
   end

   hs_coil_decode #(.NUM_COILS(NUM_COILS)) u_coil (
      .gray    (gray),
      .coil_en (coil_en)
   );

endmodule

// File: rtl/hs_step_checker.sv
module hs_step_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       sel_s,
   input logic       wr_s,
   input logic [1:0] gray,
   input logic [3:0] coil_en,
   input logic       trk0_flag,
   input logic       step_pulse
);

   p_coil_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(coil_en) == 1);

   p_flag_at_phase0_r8: assert property (@(posedge clk) disable iff (!rst_n)
      trk0_flag |-> coil_en[0]);

   p_gated_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_s || wr_s) |=> !step_pulse);

   p_no_track_minus1_r9: assert property (@(posedge clk) disable iff (!rst_n)
      trk0_flag |=> !(step_pulse && coil_en[3]));

   p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      step_pulse |=> !step_pulse);

   p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !step_pulse |-> $stable(coil_en));

   p_pulse_moves_r10: assert property (@(posedge clk) disable iff (!rst_n)
      step_pulse |-> coil_en != $past(coil_en));

   p_gray_one_bit_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(gray ^ $past(gray)) <= 1);

endmodule

bind head_step_seq hs_step_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sel_s      (sel_s),
   .wr_s       (wr_s),
   .gray       (gray),
   .coil_en    (coil_en),
   .trk0_flag  (trk0_flag),
   .step_pulse (step_pulse)
);

// File: tb/tb_head_step_seq.sv
`timescale 1ns/1ps
module tb_head_step_seq;

   localparam int SYNC = 2;
   localparam int DEB  = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic drive_sel = 1'b0;
   logic write_busy = 1'b0;
   logic step_req = 1'b0;
   logic step_dir = 1'b0;
   logic trk0_sw_n = 1'b1;
   logic [3:0] coil_en;
   logic trk0_flag;
   logic step_pulse;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   head_step_seq #(.SYNC_STAGES(SYNC), .DEBOUNCE_CYCLES(DEB)) dut (
      .clk(clk), .rst_n(rst_n), .drive_sel(drive_sel), .write_busy(write_busy),
      .step_req(step_req), .step_dir(step_dir), .trk0_sw_n(trk0_sw_n),
      .coil_en(coil_en), .trk0_flag(trk0_flag), .step_pulse(step_pulse));

   // behavioural reference: delay line of input samples, integer phase
   logic [4:0] hist[$];
   int  m_phase = 0;
   bit  m_closed = 0;
   int  m_cnt = 0;
   bit  m_prev = 0;
   bit  m_pulse = 0;

   always @(posedge clk) begin
      logic [4:0] d;
      bit rise, flag, ok;
      if (!rst_n) begin
         hist.delete();
         m_phase = 0; m_closed = 0; m_cnt = 0; m_prev = 0; m_pulse = 0;
      end else begin
         hist.push_back({drive_sel, write_busy, step_req, step_dir, trk0_sw_n});
         if (hist.size() > SYNC) d = hist.pop_front();
         else d = 5'b00001;
         rise = d[2] && !m_prev;
         m_prev = d[2];
         flag = m_closed && (m_phase == 0);
         ok = rise && d[4] && !d[3] && !(flag && !d[1]);
         if (ok) m_phase = d[1] ? (m_phase + 1) % 4 : (m_phase + 3) % 4;
         m_pulse = ok;
         if (!d[0] == m_closed) m_cnt = 0;
         else begin
            m_cnt++;
            if (m_cnt == DEB) begin m_closed = !d[0]; m_cnt = 0; end
         end
      end
   end

   task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model (R2 coil map, R8 flag, R10 pulse)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R2 coil_en", coil_en, 4'(1 << m_phase));
         check("R8 trk0_flag", {3'b0, trk0_flag}, {3'b0, m_closed && m_phase == 0});
         check("R10 step_pulse", {3'b0, step_pulse}, {3'b0, m_pulse});
      end
   end

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_step(input logic dir, input int hold);
      @(negedge clk);
      step_dir = dir;
      step_req = 1'b1;
      cycles(hold);
      step_req = 1'b0;
      cycles(6);
   endtask

   initial begin
      cycles(3);
      rst_n = 1'b1;
      cycles(1);
      // R1 reset state
      check("R1 coil_en", coil_en, 4'b0001);
      check("R1 step_pulse", {3'b0, step_pulse}, 4'b0);
      check("R1 trk0_flag", {3'b0, trk0_flag}, 4'b0);
      drive_sel = 1'b1;
      cycles(4);

      // R12 latency: pulse appears SYNC+1 edges after the first sampling edge
      @(negedge clk);
      step_dir = 1'b1; step_req = 1'b1;
      cycles(SYNC);
      check("R12 early", {3'b0, step_pulse}, 4'b0);
      cycles(1);
      check("R12 pulse", {3'b0, step_pulse}, 4'b1);
      check("R12 coil", coil_en, 4'b0010);
      step_req = 1'b0;
      cycles(6);

      // R3 inward walk 1->2->3->0->1
      for (int i = 0; i < 4; i++) do_step(1'b1, 3);
      check("R3 inward wrap", coil_en, 4'b0010);

      // R4 outward 1->0->3
      do_step(1'b0, 3);
      check("R4 outward", coil_en, 4'b0001);
      do_step(1'b0, 3);
      check("R4 outward wrap", coil_en, 4'b1000);

      // R5 held step line gives one step: 3->0
      do_step(1'b1, 20);
      check("R5 held step", coil_en, 4'b0001);

      // R6 gating by select and write
      drive_sel = 1'b0;
      do_step(1'b1, 3);
      check("R6 deselected", coil_en, 4'b0001);
      drive_sel = 1'b1; write_busy = 1'b1;
      do_step(1'b1, 3);
      check("R6 write busy", coil_en, 4'b0001);
      write_busy = 1'b0;
      cycles(4);

      // R7 glitch shorter than the window is ignored
      trk0_sw_n = 1'b0;
      cycles(DEB - 2);
      trk0_sw_n = 1'b1;
      cycles(DEB + 6);
      check("R7 glitch", {3'b0, trk0_flag}, 4'b0);

      // R7 sustained closure is reported
      trk0_sw_n = 1'b0;
      cycles(DEB + SYNC + 3);
      check("R7 closed", {3'b0, trk0_flag}, 4'b1);

      // R9 outward blocked at track zero
      do_step(1'b0, 3);
      check("R9 outward blocked", coil_en, 4'b0001);
      check("R9 flag held", {3'b0, trk0_flag}, 4'b1);
      do_step(1'b1, 3);
      check("R9 inward allowed", coil_en, 4'b0010);
      check("R8 flag off phase", {3'b0, trk0_flag}, 4'b0);
      do_step(1'b0, 3);
      check("R8 flag back at phase 0", {3'b0, trk0_flag}, 4'b1);

      // R8 switch closed at phase 2 gives no flag
      do_step(1'b1, 3);
      do_step(1'b1, 3);
      check("R8 phase 2", {3'b0, trk0_flag}, 4'b0);
      trk0_sw_n = 1'b1;
      cycles(DEB + SYNC + 3);
      do_step(1'b0, 3);
      do_step(1'b0, 3);
      check("R8 open at phase 0", {3'b0, trk0_flag}, 4'b0);
      check("R4 back to 0", coil_en, 4'b0001);

      cycles(4);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual hung expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule